// File: doc/BRIEF.md
# Power State and Clock-Enable Controller

This block tracks the power state of a media decoder chip and turns that state into clock enables and resets for the chip's units. A host microcontroller controls a hard power-down through three pins, called latch, clock and data. All three sit high in normal operation. A power-down is entered or left by pulling the latch pin low and then making a falling edge on the clock pin or the data pin. The pins are asynchronous, so each one passes through a two-flop synchronizer before any edge is detected.

The host also has a small write port with address, data and write strobe. Two addresses on that port are decoded. A write to 0xDF controls sleep. A write to 0xE0 starts a software reset. After reset, and again after leaving power-down, the chip counts as not ready until it receives a software-reset write. That write holds the decoder units in reset for a fixed 16 cycles and then lets the chip run. In sleep, only the host interface and the DRAM controller keep their clocks, so host access and DRAM refresh keep working.

The state machine has five states:
- `PS_AWAIT`: waiting for the software reset.
- `PS_SRST`: the soft-reset pulse is running.
- `PS_RUN`: normal operation.
- `PS_SLEEP`: sleep.
- `PS_PDOWN`: power-down.

It has these transitions:
- `AWAIT→SRST` on a reset write.
- `RUN→SRST` on a reset write.
- `SRST→RUN` when the pulse ends.
- `RUN→SLEEP` on a sleep-enter write.
- `SLEEP→RUN` on a wake write.
- Any state except `PDOWN` goes to `PDOWN` on a power-down pin event.
- `PDOWN→AWAIT` on a power-down-reset pin event.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `rst_n` is released, `status` is 2'b11 (not ready), `en_hif`, `en_dram` and `en_core` are 1, `core_rst` is 1 and `hif_rst` is 0. While the pins stay all high, nothing changes.
- R2: Each pin is synchronized in two stages. A falling edge driven between two clock edges changes the outputs after the third following rising edge, and not before it.
- R3: With `pin_latch` low, a falling edge on `pin_clk` moves the block from any state other than power-down into power-down. A falling edge on `pin_clk` while `pin_latch` is high has no effect.
- R4: In power-down, `status` is 2'b10, `en_hif`, `en_dram` and `en_core` are 0, and `hif_rst` and `core_rst` are 1.
- R5: With `pin_latch` low, a falling edge on `pin_data` while in power-down moves the block to not ready (2'b11). The same edge outside power-down has no effect.
- R6: A write of any data to address 0xE0 while not ready or running keeps `core_rst` at 1 and `status` at 2'b11 for exactly 16 cycles. After that, `status` is 2'b00 (running) and `core_rst` is 0. The same write while in sleep has no effect.
- R7: A write to address 0xDF with bit 7 set moves the block from running to sleep (2'b01). The same write with bit 7 clear moves it from sleep to running. Bits 6:0 are ignored. Writes to 0xDF while not ready have no effect.
- R8: In sleep, `en_hif` and `en_dram` are 1, `en_core` is 0, and both resets are 0.
- R9: A power-down pin event takes priority over a host write in the same cycle. In power-down, every host write is ignored.
- R10: Writes to any address other than 0xDF and 0xE0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| pin_latch | input | 1 | Power-down latch pin, asynchronous, idles high |
| pin_clk | input | 1 | Power-down clock pin, asynchronous, idles high |
| pin_data | input | 1 | Power-down data pin, asynchronous, idles high |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| en_hif | output | 1 | Clock enable for the host interface unit |
| en_dram | output | 1 | Clock enable for the DRAM controller |
| en_core | output | 1 | Clock enable for the remaining decoder units |
| hif_rst | output | 1 | Reset for the host interface unit |
| core_rst | output | 1 | Reset for all units except the host interface |
| status | output | 2 | 00 running, 01 sleep, 10 power-down, 11 not ready |

## Verification
The assertions check on every cycle that the output pattern matches each state:
- In power-down, everything is gated off and held in reset.
- In sleep, only the host interface and DRAM controller stay enabled.
- No host write can move the block out of power-down.
- The block never reaches running from not ready in fewer than 16 cycles of reset.

Only the bench's scenarios can show the following:
- The three-edge latency of the pin path.
- That a pin event without the latch pin low is ignored.
- That bits 6:0 of the sleep data and writes to other addresses are ignored.
- That random mixes of pin sequences and writes follow the state transitions.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int PIN_CNT    = 3;
    localparam int PIN_LATCH  = 0;
    localparam int PIN_CLK    = 1;
    localparam int PIN_DATA   = 2;

    typedef enum logic [2:0] {
        PS_AWAIT,
        PS_SRST,
        PS_RUN,
        PS_SLEEP,
        PS_PDOWN
    } pwr_state_e;

    typedef enum logic [1:0] {
        STAT_RUN    = 2'b00,
        STAT_SLEEP  = 2'b01,
        STAT_PDOWN  = 2'b10,
        STAT_NOTRDY = 2'b11
    } pwr_stat_e;

    typedef struct packed {
        logic sleep_wr;
        logic sleep_on;
        logic srst_wr;
    } host_req_t;

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_async,
    output logic [N-1:0] pins_sync,
    output logic [N-1:0] pins_fall
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                prev  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], pins_async[i]};
                prev  <= chain[LAST];
            end
        end

        assign pins_sync[i] = chain[LAST];
        assign pins_fall[i] = prev & ~chain[LAST];
    end

endmodule

// File: rtl/pwr_host_dec.sv
module pwr_host_dec
    import pwr_pkg::*;
#(
    parameter int          AW         = 8,
    parameter int          DW         = 8,
    parameter logic [AW-1:0] SLEEP_ADDR = 8'hDF,
    parameter logic [AW-1:0] SRST_ADDR  = 8'hE0,
    parameter int          SLEEP_BIT  = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    output host_req_t     req
);

    always_comb begin
        req          = '0;
        req.sleep_wr = wr && (addr == SLEEP_ADDR);
        req.sleep_on = wdata[SLEEP_BIT];
        req.srst_wr  = wr && (addr == SRST_ADDR);
    end

endmodule

// File: rtl/pwr_srst_timer.sv
module pwr_srst_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = busy && (cnt == LAST);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int SYNC_LEN = 2,
    parameter int SRST_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_latch,
    input  logic          pin_clk,
    input  logic          pin_data,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_wr,
    output logic          en_hif,
    output logic          en_dram,
    output logic          en_core,
    output logic          hif_rst,
    output logic          core_rst,
    output logic [1:0]    status
);

    logic [PIN_CNT-1:0] pins_raw, pins_s, pins_f;
    host_req_t          req;
    pwr_state_e         state, state_nx;
    logic               pd_enter, pd_exit;
    logic               t_start, t_abort, t_busy, t_done;

    assign pins_raw[PIN_LATCH] = pin_latch;
    assign pins_raw[PIN_CLK]   = pin_clk;
    assign pins_raw[PIN_DATA]  = pin_data;

    pwr_pin_sync #(.N(PIN_CNT), .STAGES(SYNC_LEN)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pins_raw),
        .pins_sync  (pins_s),
        .pins_fall  (pins_f)
    );

    pwr_host_dec #(.AW(AW), .DW(DW)) u_dec (
        .addr  (host_addr),
        .wdata (host_wdata),
        .wr    (host_wr),
        .req   (req)
    );

    pwr_srst_timer #(.LEN(SRST_LEN)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .abort (t_abort),
        .busy  (t_busy),
        .done  (t_done)
    );

    assign pd_enter = ~pins_s[PIN_LATCH] & pins_f[PIN_CLK];
    assign pd_exit  = ~pins_s[PIN_LATCH] & pins_f[PIN_DATA];

    always_comb begin
        state_nx = state;
        if (state == PS_PDOWN) begin
            if (pd_exit) state_nx = PS_AWAIT;
        end else if (pd_enter) begin
            state_nx = PS_PDOWN;
        end else begin
            unique case (state)
                PS_AWAIT: if (req.srst_wr) state_nx = PS_SRST;
                PS_SRST:  if (t_done)      state_nx = PS_RUN;
                PS_RUN: begin
                    if (req.srst_wr)                     state_nx = PS_SRST;
                    else if (req.sleep_wr && req.sleep_on) state_nx = PS_SLEEP;
                end
                PS_SLEEP: if (req.sleep_wr && !req.sleep_on) state_nx = PS_RUN;
                default:  state_nx = state;
            endcase
        end
    end

    assign t_start = (state_nx == PS_SRST) && (state != PS_SRST);
    assign t_abort = (state_nx != PS_SRST) && t_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_AWAIT;
        else        state <= state_nx;
    end

    always_comb begin
        en_hif   = 1'b1;
        en_dram  = 1'b1;
        en_core  = 1'b1;
        hif_rst  = 1'b0;
        core_rst = 1'b0;
        status   = STAT_NOTRDY;
        unique case (state)
            PS_AWAIT, PS_SRST: begin
                core_rst = 1'b1;
                status   = STAT_NOTRDY;
            end
            PS_RUN: status = STAT_RUN;
            PS_SLEEP: begin
                en_core = 1'b0;
                status  = STAT_SLEEP;
            end
            PS_PDOWN: begin
                en_hif   = 1'b0;
                en_dram  = 1'b0;
                en_core  = 1'b0;
                hif_rst  = 1'b1;
                core_rst = 1'b1;
                status   = STAT_PDOWN;
            end
            default: status = STAT_NOTRDY;
        endcase
    end

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       en_hif,
    input logic       en_dram,
    input logic       en_core,
    input logic       hif_rst,
    input logic       core_rst,
    input logic [1:0] status
);

    logic [4:0] notrdy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                notrdy_len <= '0;
        else if (status != 2'b11)  notrdy_len <= '0;
        else if (notrdy_len != '1) notrdy_len <= notrdy_len + 1'b1;
    end

    AST_PDOWN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> (!en_hif && !en_dram && !en_core && hif_rst && core_rst)); // R4

    AST_SLEEP_KEEPS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01) |-> (en_hif && en_dram && !en_core && !core_rst && !hif_rst)); // R8

    AST_PDOWN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && host_wr) |=> (status == 2'b10 || status == 2'b11)); // R9

    AST_SRST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00 && $past(status) == 2'b11) |-> ($past(notrdy_len) >= 5'd15)); // R6

    AST_NOTRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b11) |-> (core_rst && en_hif && !hif_rst)); // R1

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (host_wr),
    .en_hif   (en_hif),
    .en_dram  (en_dram),
    .en_core  (en_core),
    .hif_rst  (hif_rst),
    .core_rst (core_rst),
    .status   (status)
);

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_state_ctrl_bench;

    localparam int M_AWAIT = 0, M_RUN = 1, M_SLEEP = 2, M_PD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_latch = 1'b1, pin_clk = 1'b1, pin_data = 1'b1;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       en_hif, en_dram, en_core, hif_rst, core_rst;
    logic [1:0] status;

    int checks = 0, failures = 0;
    int model = M_AWAIT;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwr_state_ctrl u_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n),
        .pin_latch(pin_latch), .pin_clk(pin_clk), .pin_data(pin_data),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
        .en_hif(en_hif), .en_dram(en_dram), .en_core(en_core),
        .hif_rst(hif_rst), .core_rst(core_rst), .status(status)
    );

    // {status, en_hif, en_dram, en_core, hif_rst, core_rst}
    function automatic logic [6:0] exp_out(int m);
        case (m)
            M_AWAIT: return 7'b11_111_01;
            M_RUN:   return 7'b00_111_00;
            M_SLEEP: return 7'b01_110_00;
            default: return 7'b10_000_11;
        endcase
    endfunction

    function automatic logic [6:0] act_out();
        return {status, en_hif, en_dram, en_core, hif_rst, core_rst};
    endfunction

    task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_model(string req);
        chk(req, act_out(), exp_out(model));
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_pins(logic l, logic c, logic d);
        @(negedge clk);
        pin_latch = l; pin_clk = c; pin_data = d;
        wait_n(4);
    endtask

    // Applies a write and updates the model; waits out any soft-reset pulse.
    task automatic op_write(logic [7:0] a, logic [7:0] d);
        bit srst = 0;
        host_write(a, d);
        if (model != M_PD) begin
            if (a == 8'hE0 && (model == M_AWAIT || model == M_RUN)) begin
                srst = 1; model = M_RUN;
            end else if (a == 8'hDF && model == M_RUN && d[7]) model = M_SLEEP;
            else if (a == 8'hDF && model == M_SLEEP && !d[7]) model = M_RUN;
        end
        if (srst) wait_n(17);
    endtask

    task automatic op_pd_enter();
        set_pins(1'b0, 1'b1, 1'b1);
        set_pins(1'b0, 1'b0, 1'b1);
        if (model != M_PD) model = M_PD;
        set_pins(1'b1, 1'b1, 1'b1);
    endtask

    task automatic op_pd_exit();
        set_pins(1'b0, 1'b1, 1'b1);
        set_pins(1'b0, 1'b1, 1'b0);
        if (model == M_PD) model = M_AWAIT;
        set_pins(1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        chk_model("R1 reset state");
        set_pins(1'b1, 1'b1, 1'b1);
        chk_model("R1 idle pins");

        host_write(8'hDF, 8'h80);
        chk_model("R7 sleep write ignored when not ready");

        // R6 pulse length
        host_write(8'hE0, 8'h5A);
        chk("R6 pulse start", act_out(), exp_out(M_AWAIT));
        wait_n(15);
        chk("R6 pulse cycle 16", act_out(), exp_out(M_AWAIT));
        wait_n(1);
        model = M_RUN;
        chk_model("R6 running after 16 cycles");

        host_write(8'h12, 8'hFF);
        chk_model("R10 other address ignored");
        host_write(8'hDF, 8'h7F);
        chk_model("R7 bit7 clear stays running");
        host_write(8'hDF, 8'h80);
        model = M_SLEEP;
        chk_model("R7 R8 enter sleep");
        host_write(8'hE0, 8'h00);
        chk_model("R6 reset write ignored in sleep");
        host_write(8'hDF, 8'hFF);
        chk_model("R7 bit7 set stays in sleep");
        host_write(8'hDF, 8'h7F);
        model = M_RUN;
        chk_model("R7 wake ignores low bits");

        set_pins(1'b1, 1'b0, 1'b1);
        chk_model("R3 clk fall with latch high ignored");
        set_pins(1'b1, 1'b1, 1'b1);
        set_pins(1'b0, 1'b1, 1'b0);
        chk_model("R5 data fall outside power-down ignored");
        set_pins(1'b1, 1'b1, 1'b1);

        // R2 latency: latch low, then clk fall
        set_pins(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        pin_clk = 1'b0;
        wait_n(2);
        chk("R2 no change after two edges", act_out(), exp_out(M_RUN));
        wait_n(1);
        model = M_PD;
        chk_model("R2 R3 R4 power-down after third edge");
        set_pins(1'b1, 1'b1, 1'b1);
        host_write(8'hE0, 8'h00);
        chk_model("R9 reset write ignored in power-down");
        host_write(8'hDF, 8'h00);
        chk_model("R9 sleep write ignored in power-down");
        op_pd_exit();
        chk_model("R5 power-down reset to not ready");

        for (int i = 0; i < 300; i++) begin
            int k = int'($urandom_range(0, 9));
            logic [7:0] d = 8'($urandom);
            if (k < 3)      op_write(8'hDF, d);
            else if (k < 5) op_write(8'hE0, d);
            else if (k < 6) op_write(8'($urandom), d);
            else if (k < 8) op_pd_enter();
            else            op_pd_exit();
            chk_model("R3 R5 R6 R7 R9 R10 random sequence");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule